// File: doc/BRIEF.md
# Codec Command and Status Slot Controller

This block holds the command and status slots that software uses to reach the control registers of an attached AC'97-style audio codec. A small word-addressed register port on the bus side exposes two transmit slots, two receive slots and a flag register. Software first loads the data slot and then writes the command slot. The write to the command slot carries the direction and the 7-bit codec register number, and it launches one codec transaction. The block sends that transaction to the codec as a single-cycle request and then waits for a valid/ready response.

A small sequencer runs each transaction through three named states. IDLE moves to ISSUE when a command-slot write is accepted. ISSUE drives the one-cycle request and always moves on to WAIT. WAIT keeps the response-ready output high and goes back to IDLE on the cycle in which the response handshake completes. When a read completes, the receive slots are loaded. The command echo has its direction bit cleared, and the returned 16-bit value is left-justified in a 20-bit slot. The flag register records which slots are empty, busy or valid. It also records whether a command-slot write was dropped because a transaction was already in flight.

Bus word addresses: 0 command transmit slot, 1 data transmit slot, 2 command receive slot, 3 data receive slot, 4 flags. Slot registers are 20 bits wide and read back zero-extended to 32 bits.

Top module: `ac_slot_ctrl`

## Requirements
- R1: After reset the flag register reads 0x07, all four slot registers read zero, and no codec request is driven. Flag bit positions: bit 0 command-tx-empty, bit 1 data-tx-empty, bit 2 both-tx-empty, bit 3 command-rx-busy, bit 4 data-rx-busy, bit 5 command-rx-valid, bit 6 data-rx-valid, bit 7 dropped-command.
- R2: A write to address 1 stores bits 19:0 of the bus word, which then read back with bits 31:20 zero. It clears flag bits 1 and 2 and starts no codec request.
- R3: A write to address 0 while idle stores bits 19:0 and clears flag bits 0 and 2. In the following cycle it drives a one-cycle request whose read flag is bit 19, whose codec address is bits 18:12, and whose write data is bits 19:4 of the stored data slot.
- R4: A codec write (bit 19 = 0) completes on the response handshake. It sets flag bits 0, 1 and 2 and leaves both receive registers and flag bits 5 and 6 unchanged.
- R5: On completion of a codec read, address 2 holds the command word with bit 19 cleared, and address 3 holds the returned 16-bit value shifted left by 4. Flag bits 5 and 6 are set, and bits 0, 1 and 2 are set.
- R6: From the launch of a codec read until its completion, flag bits 3 and 4 are set. They are cleared when the read completes.
- R7: A bus read of address 2 clears flag bit 5 only. A bus read of address 3 clears flag bit 6 only.
- R8: A write to address 0 while a transaction is in flight is ignored: the stored command is unchanged and no further request is issued. The write sets flag bit 7, which a bus read of address 4 clears.
- R9: Addresses 5 and above read as zero, and writes to them change no register and start no request.
- R10: Response-ready is low during the request cycle and high from the cycle after it until the handshake. It is low again once the transaction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| cdc_req | output | 1 | One-cycle codec transaction request |
| cdc_rd | output | 1 | Request is a codec register read |
| cdc_addr | output | 7 | Codec register number |
| cdc_wdata | output | 16 | Codec write data |
| cdc_rsp_valid | input | 1 | Codec response valid |
| cdc_rsp_data | input | 16 | Codec read result |
| cdc_rsp_ready | output | 1 | Controller accepts a response |

## Verification
The bench builds the block with its default widths: 20-bit slots, a 7-bit codec address, 16-bit codec data and a 4-bit bus address. These sizes let it sweep every one of the 128 codec register numbers, first with writes and then with reads. Each transaction uses a codec response latency of 0 to 3 cycles taken from the address. The 4-bit address space also lets the bench probe all eleven unmapped addresses. A stretched latency holds a transaction open long enough to drop a second command into it.

// File: rtl/ac_slot_pkg.sv
package ac_slot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    // Flag register bit positions
    localparam int FLG_S1_TXE = 0;
    localparam int FLG_S2_TXE = 1;
    localparam int FLG_BOTH_TXE = 2;
    localparam int FLG_S1_RXB = 3;
    localparam int FLG_S2_RXB = 4;
    localparam int FLG_S1_RXV = 5;
    localparam int FLG_S2_RXV = 6;
    localparam int FLG_DROP = 7;
    localparam int FLG_W = 8;
    localparam logic [FLG_W-1:0] FLG_RESET = 8'h07;

    // Register word addresses
    localparam int RG_S1TX = 0;
    localparam int RG_S2TX = 1;
    localparam int RG_S1RX = 2;
    localparam int RG_S2RX = 3;
    localparam int RG_FLAGS = 4;

endpackage

// File: rtl/ac_slot_seq.sv
module ac_slot_seq
    import ac_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic rsp_valid,
    output logic busy,
    output logic req,
    output logic rsp_ready,
    output logic done
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        req       = 1'b0;
        rsp_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin
                busy = 1'b1;
                req  = 1'b1;
            end
            ST_WAIT: begin
                busy      = 1'b1;
                rsp_ready = 1'b1;
                done      = rsp_valid;
            end
            default: ;
        endcase
    end

    // R3: an accepted launch produces exactly one request cycle
    p_launch_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> req);
    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    // R10: ready follows the request and holds until the handshake
    p_ready_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_ready);
    p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && !rsp_valid) |=> rsp_ready);
    // R8: a launch is only ever accepted while idle
    p_launch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);

endmodule

// File: rtl/ac_slot_regs.sv
module ac_slot_regs
    import ac_slot_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int CA_W   = 7,
    parameter int DATA_W = 16,
    parameter int BUS_W  = 32,
    parameter int RA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [RA_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              launch,
    output logic              cmd_rd,
    output logic [CA_W-1:0]   cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata
);

    localparam int DIR_BIT  = SLOT_W - 1;
    localparam int ADDR_HI  = SLOT_W - 2;
    localparam int ADDR_LO  = SLOT_W - 1 - CA_W;
    localparam int RX_SHIFT = SLOT_W - DATA_W;
    localparam int PAD_W    = BUS_W - SLOT_W;

    logic [SLOT_W-1:0] s1tx_q, s2tx_q, s1rx_q, s2rx_q;
    logic [FLG_W-1:0]  flags_q;

    logic sel_s1tx, sel_s2tx, sel_s1rx, sel_s2rx, sel_flags;
    logic wr_s1, collide;
    logic unused_hi;

    assign sel_s1tx  = (bus_addr == RA_W'(RG_S1TX));
    assign sel_s2tx  = (bus_addr == RA_W'(RG_S2TX));
    assign sel_s1rx  = (bus_addr == RA_W'(RG_S1RX));
    assign sel_s2rx  = (bus_addr == RA_W'(RG_S2RX));
    assign sel_flags = (bus_addr == RA_W'(RG_FLAGS));

    assign wr_s1   = bus_wr && sel_s1tx;
    assign launch  = wr_s1 && !busy;
    assign collide = wr_s1 && busy;
    assign unused_hi = ^bus_wdata[BUS_W-1:SLOT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1tx_q    <= '0;
            s2tx_q    <= '0;
            s1rx_q    <= '0;
            s2rx_q    <= '0;
            flags_q   <= FLG_RESET;
            cmd_rd    <= 1'b0;
            cmd_addr  <= '0;
            cmd_wdata <= '0;
        end else begin
            // read side effects first so that later events win
            if (bus_rd && sel_s1rx)  flags_q[FLG_S1_RXV] <= 1'b0;
            if (bus_rd && sel_s2rx)  flags_q[FLG_S2_RXV] <= 1'b0;
            if (bus_rd && sel_flags) flags_q[FLG_DROP]   <= 1'b0;

            if (done) begin
                flags_q[FLG_S1_TXE]   <= 1'b1;
                flags_q[FLG_S2_TXE]   <= 1'b1;
                flags_q[FLG_BOTH_TXE] <= 1'b1;
                if (cmd_rd) begin
                    s1rx_q <= {1'b0, s1tx_q[DIR_BIT-1:0]};
                    s2rx_q <= {rsp_data, {RX_SHIFT{1'b0}}};
                    flags_q[FLG_S1_RXB] <= 1'b0;
                    flags_q[FLG_S2_RXB] <= 1'b0;
                    flags_q[FLG_S1_RXV] <= 1'b1;
                    flags_q[FLG_S2_RXV] <= 1'b1;
                end
            end

            if (bus_wr && sel_s2tx) begin
                s2tx_q <= bus_wdata[SLOT_W-1:0];
                flags_q[FLG_S2_TXE]   <= 1'b0;
                flags_q[FLG_BOTH_TXE] <= 1'b0;
            end

            if (launch) begin
                s1tx_q    <= bus_wdata[SLOT_W-1:0];
                cmd_rd    <= bus_wdata[DIR_BIT];
                cmd_addr  <= bus_wdata[ADDR_HI:ADDR_LO];
                cmd_wdata <= s2tx_q[SLOT_W-1 -: DATA_W];
                flags_q[FLG_S1_TXE]   <= 1'b0;
                flags_q[FLG_BOTH_TXE] <= 1'b0;
                if (bus_wdata[DIR_BIT]) begin
                    flags_q[FLG_S1_RXB] <= 1'b1;
                    flags_q[FLG_S2_RXB] <= 1'b1;
                end
            end

            if (collide) flags_q[FLG_DROP] <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_s1tx)       bus_rdata = {{PAD_W{1'b0}}, s1tx_q};
        else if (sel_s2tx)  bus_rdata = {{PAD_W{1'b0}}, s2tx_q};
        else if (sel_s1rx)  bus_rdata = {{PAD_W{1'b0}}, s1rx_q};
        else if (sel_s2rx)  bus_rdata = {{PAD_W{1'b0}}, s2rx_q};
        else if (sel_flags) bus_rdata = {{(BUS_W-FLG_W){1'b0}}, flags_q};
    end

    // R8: a command write during a transaction is dropped and flagged
    p_drop_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (flags_q[FLG_DROP] && $stable(s1tx_q)));
    // R5: read completion fills both receive slots as valid
    p_read_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_rd) |=> (flags_q[FLG_S1_RXV] && flags_q[FLG_S2_RXV]
                              && !flags_q[FLG_S1_RXB] && !flags_q[FLG_S2_RXB]));
    // R2: a data-slot write leaves the data slot marked not empty
    p_s2_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_s2tx) |=> !flags_q[FLG_S2_TXE]);
    // R6: receive-busy only while the sequencer is active
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[FLG_S1_RXB] || flags_q[FLG_S2_RXB]) |-> busy);
    // R4: a codec write completion leaves the receive slots alone
    p_write_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cmd_rd) |=> ($stable(s1rx_q) && $stable(s2rx_q)));

endmodule

// File: rtl/ac_slot_ctrl.sv
module ac_slot_ctrl
    import ac_slot_pkg::*;
#(
    parameter int SLOT_W = 20,
    parameter int CA_W   = 7,
    parameter int DATA_W = 16,
    parameter int BUS_W  = 32,
    parameter int RA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [RA_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              cdc_req,
    output logic              cdc_rd,
    output logic [CA_W-1:0]   cdc_addr,
    output logic [DATA_W-1:0] cdc_wdata,
    input  logic              cdc_rsp_valid,
    input  logic [DATA_W-1:0] cdc_rsp_data,
    output logic              cdc_rsp_ready
);

    logic launch, busy, done;

    ac_slot_regs #(
        .SLOT_W (SLOT_W),
        .CA_W   (CA_W),
        .DATA_W (DATA_W),
        .BUS_W  (BUS_W),
        .RA_W   (RA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .rsp_data  (cdc_rsp_data),
        .launch    (launch),
        .cmd_rd    (cdc_rd),
        .cmd_addr  (cdc_addr),
        .cmd_wdata (cdc_wdata)
    );

    ac_slot_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .rsp_valid (cdc_rsp_valid),
        .busy      (busy),
        .req       (cdc_req),
        .rsp_ready (cdc_rsp_ready),
        .done      (done)
    );

endmodule

// File: tb/ac_slot_ctrl_bench.sv
`timescale 1ns/1ps
module ac_slot_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cdc_req, cdc_rd, cdc_rsp_ready;
    logic [6:0]  cdc_addr;
    logic [15:0] cdc_wdata;
    logic        rsp_valid;
    logic [15:0] rsp_data;

    int tests = 0, fails = 0, reqcnt = 0, lat = 0;

    always #2.5 clk = ~clk;

    ac_slot_ctrl u_ac_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cdc_req(cdc_req), .cdc_rd(cdc_rd), .cdc_addr(cdc_addr),
        .cdc_wdata(cdc_wdata), .cdc_rsp_valid(rsp_valid),
        .cdc_rsp_data(rsp_data), .cdc_rsp_ready(cdc_rsp_ready)
    );

    // codec stub
    logic [15:0] cmem [128];
    logic        pend;
    int          cnt;
    logic [15:0] rdbuf;
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; cnt <= 0; rsp_valid <= 1'b0; rsp_data <= '0; rdbuf <= '0;
        end else begin
            if (rsp_valid && cdc_rsp_ready) rsp_valid <= 1'b0;
            if (cdc_req) begin
                reqcnt = reqcnt + 1;
                pend <= 1'b1; cnt <= lat;
                if (!cdc_rd) cmem[cdc_addr] <= cdc_wdata;
                rdbuf <= cmem[cdc_addr];
            end else if (pend) begin
                if (cnt != 0) cnt <= cnt - 1;
                else begin rsp_valid <= 1'b1; rsp_data <= rdbuf; pend <= 1'b0; end
            end
        end
    end

    function automatic logic [15:0] dval(input int a);
        return 16'((a * 40503) ^ 16'hA5C3);
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic bw(input int a, input logic [31:0] d);
        @(negedge clk); bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic br(input int a, output logic [31:0] v);
        @(negedge clk); bus_addr = 4'(a); bus_rd = 1'b1; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic pk(input int a, output logic [31:0] v);
        bus_addr = 4'(a); #1 v = bus_rdata;
    endtask

    task automatic wait_done;
        logic [31:0] f;
        int k;
        for (k = 0; k < 40; k++) begin
            @(negedge clk); pk(4, f);
            if (f[0]) break;
        end
        chk("R4/R5 completion", 32'(k < 40), 32'd1);
    endtask

    // issue a command; checks request fields, ready timing, busy flags
    task automatic run_cmd(input logic [31:0] w, input int l, input logic [15:0] exp_wd);
        logic [31:0] f;
        lat = l;
        bw(0, w);
        chk("R3 req", 32'(cdc_req), 32'd1);
        chk("R3 rd", 32'(cdc_rd), 32'(w[19]));
        chk("R3 addr", 32'(cdc_addr), 32'(w[18:12]));
        if (!w[19]) chk("R3 wdata", 32'(cdc_wdata), 32'(exp_wd));
        chk("R10 ready low in request", 32'(cdc_rsp_ready), 32'd0);
        pk(4, f);
        chk("R3 tx empty cleared", 32'(f[2:0] & 3'b101), 32'd0);
        if (w[19]) chk("R6 busy set", 32'(f[4:3]), 32'd3);
        @(negedge clk);
        chk("R3 req single", 32'(cdc_req), 32'd0);
        chk("R10 ready high", 32'(cdc_rsp_ready), 32'd1);
        wait_done;
        chk("R10 ready low after", 32'(cdc_rsp_ready), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, f, s1m, s2m, rx1, rx2;
        int rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin pk(a, v); chk("R1 slot zero", v, 32'd0); end
        pk(4, v); chk("R1 flags", v, 32'h07);
        chk("R1 no req", 32'(cdc_req), 32'd0);

        // R2 data slot write
        rc = reqcnt;
        bw(1, 32'hABCD_E123);
        pk(1, v); chk("R2 readback", v, 32'h000D_E123);
        pk(4, v); chk("R2 flags", v, 32'h01);
        @(negedge clk);
        chk("R2 no req", 32'(reqcnt - rc), 32'd0);

        // write sweep over all codec addresses (R3, R4)
        for (int a = 0; a < 128; a++) begin
            s2m = {12'h000, dval(a), 4'(a)};
            bw(1, {12'hC3A, dval(a), 4'(a)});
            pk(1, v); chk("R2 stored", v, s2m);
            s1m = {12'h5A5, 1'b0, 7'(a), 12'(a * 3)};
            run_cmd(s1m, a % 4, dval(a));
            pk(0, v); chk("R3 cmd stored", v, {12'h0, s1m[19:0]});
            pk(4, v); chk("R4 flags after write", v, 32'h07);
        end

        // read sweep (R5, R6, R7)
        for (int a = 0; a < 128; a++) begin
            s1m = {12'h0F0, 1'b1, 7'(a), 12'hABC};
            run_cmd(s1m, (a + 1) % 4, 16'h0);
            pk(4, v); chk("R5 flags after read", v, 32'h67);
            pk(2, v); chk("R5 cmd echo", v, {12'h0, 1'b0, 7'(a), 12'hABC});
            pk(3, v); chk("R5 data left justified", v, {12'h0, dval(a), 4'h0});
            br(2, v); pk(4, f); chk("R7 cmd valid clear", f, 32'h47);
            br(3, v); pk(4, f); chk("R7 data valid clear", f, 32'h07);
        end

        // R4: write completion keeps valid flags and receive slots
        run_cmd({12'h0, 1'b1, 7'd17, 12'h001}, 0, 16'h0);
        pk(2, rx1); pk(3, rx2);
        bw(1, 32'h0001_2340);
        run_cmd({12'h0, 1'b0, 7'd100, 12'h000}, 2, 16'h1234);
        pk(4, v); chk("R4 valid kept", v, 32'h67);
        pk(2, v); chk("R4 cmd rx kept", v, rx1);
        pk(3, v); chk("R4 data rx kept", v, rx2);
        chk("R4 codec written", 32'(cmem[100]), 32'h1234);
        br(2, v); br(3, v);

        // R8 dropped command
        rc = reqcnt;
        lat = 8;
        bw(0, {12'h0, 1'b1, 7'd5, 12'h0});
        bw(0, {12'h0, 1'b0, 7'd9, 12'h0});
        pk(4, f); chk("R8 drop flag", 32'(f[7]), 32'd1);
        pk(0, v); chk("R8 cmd kept", v, {12'h0, 1'b1, 7'd5, 12'h0});
        wait_done;
        @(negedge clk);
        chk("R8 single request", 32'(reqcnt - rc), 32'd1);
        pk(3, v); chk("R8 first command served", v, {12'h0, dval(5), 4'h0});
        br(4, v); chk("R8 drop flag read", 32'(v[7]), 32'd1);
        pk(4, v); chk("R8 drop flag cleared", 32'(v[7]), 32'd0);

        // R9 unmapped addresses
        rc = reqcnt;
        pk(0, s1m); pk(1, s2m); pk(2, rx1); pk(3, rx2); pk(4, f);
        for (int a = 5; a < 16; a++) begin
            bw(a, 32'hFFFF_FFFF);
            br(a, v); chk("R9 reads zero", v, 32'd0);
        end
        pk(0, v); chk("R9 s1tx unchanged", v, s1m);
        pk(1, v); chk("R9 s2tx unchanged", v, s2m);
        pk(2, v); chk("R9 s1rx unchanged", v, rx1);
        pk(3, v); chk("R9 s2rx unchanged", v, rx2);
        pk(4, v); chk("R9 flags unchanged", v, f);
        chk("R9 no request", 32'(reqcnt - rc), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule